// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral for a system bus. A down counter runs at the system clock and is reloaded from a programmable load value. When the counter passes through zero for the first time, it latches an interrupt. If that interrupt has not been serviced by the time the counter passes through zero again, the block issues a one-cycle system reset request, provided reset generation is enabled.

Software controls the block through eight word-indexed registers on a simple synchronous write port with a combinational read port. Software services the watchdog by writing the clear register, which drops the interrupt and restarts the count. A key-protected lock freezes the configuration once it is set up. An optional stall bit holds the counter while an external debug-halt input is high.

The counter width and the unlock key are parameters. A third parameter decides whether the stall feature is built at all.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, LOAD (word 0) and COUNT (word 1) read 2^CNT_W-1. CTRL (word 2), RAW (word 4), MASKED (word 5), LOCK (word 6) and STALL (word 7) read 0. `irq_o` and `rst_req_o` are low. Unused bits always read 0.
- R2: While CTRL bit 0 is set and the counter is not stalled, COUNT decreases by one each clock. In the cycle after it reads 0, it reloads from LOAD and RAW bit 0 sets. The first expiry therefore comes LOAD+1 clocks after counting starts from LOAD.
- R3: CTRL bit 0 (run) is sticky: a write of 0 does not clear it, and only reset does. Setting it also arms the interrupt. MASKED bit 0 and `irq_o` equal RAW bit 0 AND run.
- R4: An accepted write to LOAD stores the lower CNT_W data bits and makes COUNT equal to that value on the next clock.
- R5: Any write to CLR (word 3) clears RAW and reloads COUNT from LOAD. It takes precedence over an expiry in the same cycle, so that expiry neither sets RAW nor requests a reset.
- R6: An expiry while RAW is already set and CTRL bit 1 (reset enable) is set drives `rst_req_o` high for exactly the following clock. With CTRL bit 1 clear, no reset request is ever made.
- R7: Writing the 32-bit key UNLOCK_KEY to LOCK unlocks the block, and writing any other value locks it. LOCK reads 1 when locked and 0 when unlocked. While locked, writes to LOAD, CTRL and STALL are ignored, and CLR still works.
- R8: When STALL bit 0 is set and `dbg_halt_i` is high, COUNT holds and no expiry occurs. If either of the two is low, counting proceeds.
- R9: COUNT is read-only, so writes to word 1 have no effect. The register at word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one write per asserted clock |
| bus_addr_i | input | 3 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| dbg_halt_i | input | 1 | Debug halt indication |
| irq_o | output | 1 | Interrupt level, equal to the masked status |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with a 16-bit counter, stall support present, and the default key. Small load values make the first-expiry and second-expiry timing, the clear-versus-expiry collision and the lock behaviour cheap to reach. The 16-bit width also keeps one full-width run affordable. That run checks that a 32-bit load write is truncated to the counter width, and that the expiry arrives exactly 65536 clocks after the restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_LOAD  = 3'd0,
      A_COUNT = 3'd1,
      A_CTRL  = 3'd2,
      A_CLR   = 3'd3,
      A_RAW   = 3'd4,
      A_MASK  = 3'd5,
      A_LOCK  = 3'd6,
      A_STALL = 3'd7
   } reg_addr_e;

   localparam int CTRL_RUN_BIT   = 0;
   localparam int CTRL_RSTEN_BIT = 1;

   localparam logic [DATA_W-1:0] DEFAULT_KEY = 32'h5A3C_96E1;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
   import wdog_pkg::*;
#(
   parameter int                CNT_W      = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DEFAULT_KEY,
   parameter bit                STALL_OPT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              raw_i,
   output logic [CNT_W-1:0]  load_q,
   output logic              run_q,
   output logic              rsten_q,
   output logic              stall_en_o,
   output logic              load_wr_o,
   output logic              clr_o,
   output logic [DATA_W-1:0] rdata_o
);

   reg_addr_e sel;
   logic      lock_q;
   logic      cfg_ok;

   assign sel       = reg_addr_e'(addr_i);
   assign cfg_ok    = wr_i & ~lock_q;
   assign load_wr_o = cfg_ok & (sel == A_LOAD);
   assign clr_o     = wr_i & (sel == A_CLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q  <= '1;
         run_q   <= 1'b0;
         rsten_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         if (load_wr_o) load_q <= wdata_i[CNT_W-1:0];
         if (cfg_ok && sel == A_CTRL) begin
            run_q   <= run_q | wdata_i[CTRL_RUN_BIT];
            rsten_q <= wdata_i[CTRL_RSTEN_BIT];
         end
         if (wr_i && sel == A_LOCK) lock_q <= (wdata_i != UNLOCK_KEY);
      end
   end

   generate
      if (STALL_OPT) begin : g_stall
         logic stall_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                        stall_q <= 1'b0;
            else if (cfg_ok && sel == A_STALL) stall_q <= wdata_i[0];
         end
         assign stall_en_o = stall_q;
      end else begin : g_nostall
         assign stall_en_o = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      case (sel)
         A_LOAD:  rdata_o = DATA_W'(load_q);
         A_COUNT: rdata_o = DATA_W'(cnt_i);
         A_CTRL:  rdata_o = {{(DATA_W-2){1'b0}}, rsten_q, run_q};
         A_RAW:   rdata_o = {{(DATA_W-1){1'b0}}, raw_i};
         A_MASK:  rdata_o = {{(DATA_W-1){1'b0}}, raw_i & run_q};
         A_LOCK:  rdata_o = {{(DATA_W-1){1'b0}}, lock_q};
         A_STALL: rdata_o = {{(DATA_W-1){1'b0}}, stall_en_o};
         default: rdata_o = '0;
      endcase
   end

   // R7
   lock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_i && sel == A_LOAD) |=> $stable(load_q));

   // R3
   run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             stall_i,
   input  logic             sw_load_i,
   input  logic [CNT_W-1:0] sw_val_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire_o
);

   logic tick;
   logic at_zero;

   assign tick     = run_i & ~stall_i;
   assign at_zero  = (cnt_q == '0);
   assign expire_o = tick & at_zero & ~sw_load_i & ~clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '1;
      else if (sw_load_i) cnt_q <= sw_val_i;
      else if (clr_i)     cnt_q <= reload_i;
      else if (tick)      cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !sw_load_i && !clr_i) |=> $stable(cnt_q));

   // R4
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_load_i |=> (cnt_q == $past(sw_val_i)));

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clr_i,
   input  logic run_i,
   input  logic rsten_i,
   output logic raw_q,
   output logic irq_o,
   output logic rst_req_o
);

   logic rst_req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q     <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= expire_i & raw_q & rsten_i;
         if (clr_i)         raw_q <= 1'b0;
         else if (expire_i) raw_q <= 1'b1;
      end
   end

   assign irq_o     = raw_q & run_i;
   assign rst_req_o = rst_req_q;

   // R6
   rst_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(raw_q) && $past(rsten_i) && $past(expire_i)));

   // R5
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!raw_q && !rst_req_o));

   // R2
   expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !clr_i) |=> raw_q);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdog_pkg::*;
#(
   parameter int                CNT_W      = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DEFAULT_KEY,
   parameter bit                STALL_OPT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              dbg_halt_i,
   output logic              irq_o,
   output logic              rst_req_o
);

   generate
      if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_width
         $error("wdog_two_stage: CNT_W must lie in 4..32");
      end
   endgenerate

   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             rsten_q;
   logic             stall_en;
   logic             load_wr;
   logic             clr;
   logic             raw_q;
   logic             expire;
   logic             stall_now;

   assign stall_now = stall_en & dbg_halt_i;

   wdog_regfile #(
      .CNT_W      (CNT_W),
      .UNLOCK_KEY (UNLOCK_KEY),
      .STALL_OPT  (STALL_OPT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .cnt_i      (cnt_q),
      .raw_i      (raw_q),
      .load_q     (load_q),
      .run_q      (run_q),
      .rsten_q    (rsten_q),
      .stall_en_o (stall_en),
      .load_wr_o  (load_wr),
      .clr_o      (clr),
      .rdata_o    (bus_rdata_o)
   );

   wdog_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .stall_i   (stall_now),
      .sw_load_i (load_wr),
      .sw_val_i  (bus_wdata_i[CNT_W-1:0]),
      .clr_i     (clr),
      .reload_i  (load_q),
      .cnt_q     (cnt_q),
      .expire_o  (expire)
   );

   wdog_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (expire),
      .clr_i     (clr),
      .run_i     (run_q),
      .rsten_i   (rsten_q),
      .raw_q     (raw_q),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   // R3
   irq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (run_q && raw_q));

endmodule

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/1ps
module sim_wdog_two_stage;

   localparam int          CW   = 16;
   localparam longint      MSK  = (64'd1 << CW) - 1;
   localparam logic [31:0] KEY  = 32'h5A3C_96E1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dbg_halt = 1'b0;
   logic        irq, rst_req;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   wdog_two_stage #(.CNT_W(CW), .UNLOCK_KEY(KEY), .STALL_OPT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .dbg_halt_i(dbg_halt),
      .irq_o(irq), .rst_req_o(rst_req)
   );

   // behavioural reference model
   longint m_load, m_cnt;
   bit     m_run, m_rsten, m_lock, m_stall, m_raw, m_rst;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_load = MSK; m_cnt = MSK; m_run = 0; m_rsten = 0;
         m_lock = 0; m_stall = 0; m_raw = 0; m_rst = 0;
      end else begin
         bit do_load, do_clr, halted, fire;
         longint nxt;
         do_load = bus_wr && bus_addr == 0 && !m_lock;
         do_clr  = bus_wr && bus_addr == 3;
         halted  = m_stall && dbg_halt;
         fire    = m_run && !halted && m_cnt == 0 && !do_load && !do_clr;
         m_rst   = fire && m_raw && m_rsten;
         nxt = m_cnt;
         if (do_load)              nxt = bus_wdata & MSK;
         else if (do_clr)          nxt = m_load;
         else if (m_run && !halted) nxt = (m_cnt == 0) ? m_load : m_cnt - 1;
         m_cnt = nxt;
         if (do_clr)    m_raw = 0;
         else if (fire) m_raw = 1;
         if (do_load) m_load = bus_wdata & MSK;
         if (bus_wr && bus_addr == 2 && !m_lock) begin
            m_run   = m_run | bus_wdata[0];
            m_rsten = bus_wdata[1];
         end
         if (bus_wr && bus_addr == 7 && !m_lock) m_stall = bus_wdata[0];
         if (bus_wr && bus_addr == 6) m_lock = (bus_wdata != KEY);
      end
   end

   function automatic longint model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_load;
         3'd1: return m_cnt;
         3'd2: return {m_rsten, m_run};
         3'd4: return m_raw;
         3'd5: return m_raw & m_run;
         3'd6: return m_lock;
         3'd7: return m_stall;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         #3;
         chk("R3 irq vs model", irq, m_raw & m_run);
         chk("R6 rst_req vs model", rst_req, m_rst);
         chk("R2/R9 rdata vs model", bus_rdata, model_read(bus_addr));
      end
   end

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output longint v);
      bus_addr = a; #1; v = bus_rdata;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      longint v, c0;
      int pulses;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      rd(0, v); chk("R1 load", v, MSK);
      rd(1, v); chk("R1 count", v, MSK);
      rd(2, v); chk("R1 ctrl", v, 0);
      rd(4, v); chk("R1 raw", v, 0);
      rd(6, v); chk("R1 lock", v, 0);
      rd(7, v); chk("R1 stall", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 rst_req", rst_req, 0);
      // R9 count read-only
      wr(1, 32'h1234);
      rd(1, v); chk("R9 count write ignored", v, MSK);
      rd(3, v); chk("R9 clr reads 0", v, 0);
      // R4 load reloads immediately
      wr(0, 32'hABCD_000A);
      rd(1, v); chk("R4 count after load", v, 10);
      rd(0, v); chk("R4 load truncated", v, 10);
      // R2 count and first expiry
      wr(2, 32'h1);
      repeat (3) cyc();
      rd(1, v); chk("R2 count step", v, 7);
      repeat (7) cyc();
      rd(1, v); chk("R2 at zero", v, 0);
      rd(4, v); chk("R2 raw before expiry", v, 0);
      cyc();
      rd(4, v); chk("R2 raw after expiry", v, 1);
      rd(1, v); chk("R2 reloaded", v, 10);
      chk("R3 irq armed by run", irq, 1);
      rd(5, v); chk("R3 masked", v, 1);
      // R3 sticky run
      wr(2, 32'h0);
      rd(2, v); chk("R3 run sticky", v & 1, 1);
      // R5 clear
      wr(3, 32'h0);
      rd(4, v); chk("R5 raw cleared", v, 0);
      rd(1, v); chk("R5 count reloaded", v, 10);
      // R6 second expiry reset
      wr(2, 32'h3);
      wr(3, 32'h0);
      repeat (21) cyc();
      chk("R6 no rst before second expiry", rst_req, 0);
      cyc();
      chk("R6 rst pulse", rst_req, 1);
      cyc();
      chk("R6 rst single cycle", rst_req, 0);
      // R5 clear beats simultaneous expiry
      wr(3, 32'h0);
      repeat (10) cyc();
      rd(1, v); chk("R5 count at zero", v, 0);
      wr(3, 32'h0);
      rd(4, v); chk("R5 clear wins raw", v, 0);
      rd(1, v); chk("R5 clear wins count", v, 10);
      // R7 lock
      wr(6, 32'h0000_1234);
      rd(6, v); chk("R7 locked", v, 1);
      wr(0, 32'h3);
      rd(0, v); chk("R7 load ignored", v, 10);
      wr(2, 32'h0);
      rd(2, v); chk("R7 ctrl ignored", v, 3);
      wr(7, 32'h1);
      rd(7, v); chk("R7 stall ignored", v, 0);
      wr(3, 32'h0);
      rd(1, v); chk("R7 clear works while locked", v, 10);
      wr(6, KEY);
      rd(6, v); chk("R7 unlocked", v, 0);
      // R6 no reset when disabled
      wr(2, 32'h1);
      wr(3, 32'h0);
      pulses = 0;
      for (int i = 0; i < 30; i++) begin
         cyc();
         if (rst_req) pulses++;
      end
      chk("R6 no pulse when disabled", pulses, 0);
      // R8 stall
      wr(7, 32'h1);
      wr(3, 32'h0);
      dbg_halt = 1'b1;
      cyc();
      rd(1, c0);
      repeat (20) cyc();
      rd(1, v); chk("R8 held while halted", v, c0);
      rd(4, v); chk("R8 no expiry while halted", v, 0);
      dbg_halt = 1'b0;
      repeat (3) cyc();
      rd(1, v); chk("R8 resumes", v, c0 - 3);
      wr(7, 32'h0);
      dbg_halt = 1'b1;
      rd(1, c0);
      repeat (2) cyc();
      rd(1, v); chk("R8 halt without stall bit", v, c0 - 2);
      dbg_halt = 1'b0;
      // R4 full-width run
      wr(0, 32'hFFFF_FFFF);
      wr(3, 32'h0);
      rd(1, v); chk("R4 full width load", v, MSK);
      repeat (65535) cyc();
      rd(4, v); chk("R2 full width no early expiry", v, 0);
      cyc();
      rd(4, v); chk("R2 full width expiry", v, 1);
      rd(1, v); chk("R2 full width reload", v, MSK);
      summary();
      $finish;
   end

endmodule